// File: doc/BRIEF.md
# Per-Destination Page List Map

This block keeps the bookkeeping for a large shared packet buffer that is divided into fixed-size pages. Every destination owns a queue of pages chained through a next-page table. The block stores, per destination, the head page that is drained for transmission and the tail page that receives new data. It also keeps the read position inside the head page, the write position inside the tail page and the number of useful bytes queued. The buffer itself and all data movement live elsewhere; this block only hands out addresses and lengths.

A burst-write request names a destination and a byte count. The reply is the buffer address where the burst must land. A burst never straddles two pages: if it does not fit in the space left in the tail page, a fresh page is taken from a free pool and linked behind the tail, and the unused end of the old page becomes padding. A read request names a destination and the largest number of bytes the caller can take. The reply gives the address and length to fetch from the head page. A fully drained page goes back to the pool, and the reply reports how much padding that page carried. One write and one read can be presented in the same cycle, also for the same destination.

Top module: `page_list_map`

## Requirements
- R1: After reset every list is empty, no reply is flagged, and the free pool holds every page in ascending order, so the first allocations take page 0, then 1, and so on.
- R2: A write to an empty list takes the page at the head of the pool and returns address page*PAGE_BYTES (offset 0) with wr_new_page=1.
- R3: A write whose length fits in the space left in the tail page is placed at tail*PAGE_BYTES + write offset, with wr_new_page=0; the write offset then advances by the length.
- R4: A write that does not fit in the tail page links a new pool page after the tail and returns that page's base address with wr_new_page=1; the rest of the old tail page becomes padding.
- R5: A write is refused (wr_ok=0, no state change) when its length is 0 or above PAGE_BYTES, or when it needs a page and no page is available, counting a page freed in the same cycle.
- R6: A read of a non-empty list returns address head*PAGE_BYTES + read offset and length min(rd_max, unread useful bytes of the head page); a partial read advances the read offset.
- R7: A read of an empty list, or a read that moves zero bytes, returns rd_empty=1 and rd_len=0 and leaves the list unchanged.
- R8: A read that takes the last useful byte of the head page releases that page (rd_release=1, rd_pad = PAGE_BYTES minus the useful bytes written to the page) and moves the head to the next linked page; if it was the only page, the list becomes empty.
- R9: rd_left reports the useful bytes still queued for the read destination after the read, not counting a write in the same cycle.
- R10: For a write and a read to the same destination in one cycle, the read acts first and the write acts on its result. If the read drains the only page and the write fits in that page, the page is kept and the write lands right after the drained data. Otherwise the page is released and the write proceeds as if the list were empty.
- R11: Every request is answered exactly one cycle later (wr_ack, rd_ack), and a write and a read can be accepted in every cycle for any pair of destinations.
- R12: The pool is first-in first-out: released pages are reused only after the pages already in it. A page released while the pool is empty can be taken by a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Burst-write request |
| wr_dest | input | idx_w(NUM_DEST) | Destination of the write |
| wr_len | input | cnt_w(PAGE_BYTES) | Byte count of the write burst |
| rd_req | input | 1 | Page-read request |
| rd_dest | input | idx_w(NUM_DEST) | Destination to read |
| rd_max | input | cnt_w(PAGE_BYTES) | Largest byte count the reader accepts |
| wr_ack | output | 1 | Write reply valid |
| wr_ok | output | 1 | Write accepted |
| wr_new_page | output | 1 | Write opened a new page |
| wr_addr | output | idx_w(NUM_PAGES*PAGE_BYTES) | Buffer byte address for the write |
| rd_ack | output | 1 | Read reply valid |
| rd_empty | output | 1 | No bytes to transfer |
| rd_release | output | 1 | Head page returned to the pool |
| rd_addr | output | idx_w(NUM_PAGES*PAGE_BYTES) | Buffer byte address to read |
| rd_len | output | cnt_w(PAGE_BYTES) | Bytes to read |
| rd_pad | output | cnt_w(PAGE_BYTES) | Padding bytes in the released page |
| rd_left | output | cnt_w(NUM_PAGES*PAGE_BYTES) | Useful bytes still queued after the read |

## Verification
The hardest situation to reach is a same-cycle write and read on one destination where the read drains the only page. Whether the page is kept or recycled then depends on the write length against the room left. When the pool is also empty, it further depends on the pool handing the just-freed page straight to the write. Directed sequences first fill one page exactly, then exhaust the pool across the other destinations, and then issue the colliding pair with lengths on both sides of the fit boundary. A long pseudo-random run on a small configuration (four destinations, eight 16-byte pages, lengths 0 to 17) then compares every reply with an arithmetic model of the page queues and the pool.

// File: rtl/plm_pkg.sv
package plm_pkg;

    localparam int DEF_NUM_DEST   = 4;
    localparam int DEF_NUM_PAGES  = 8;
    localparam int DEF_PAGE_BYTES = 64;

    // index width for n items, at least one bit
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // width able to hold the values 0..n
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction

    // what a read does to the list it targets
    typedef enum logic [1:0] {
        RD_NONE    = 2'd0,
        RD_PARTIAL = 2'd1,
        RD_KEEP    = 2'd2,
        RD_RELEASE = 2'd3
    } rd_action_e;

endpackage

// File: rtl/plm_free_pool.sv
module plm_free_pool #(
    parameter int NUM_PAGES = plm_pkg::DEF_NUM_PAGES
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 push,
    input  logic [plm_pkg::idx_w(NUM_PAGES)-1:0] push_id,
    input  logic                                 pop,
    output logic                                 avail,
    output logic [plm_pkg::idx_w(NUM_PAGES)-1:0] head_id
);
    localparam int PAGE_W = plm_pkg::idx_w(NUM_PAGES);
    localparam int CNT_W  = plm_pkg::cnt_w(NUM_PAGES);

    logic [PAGE_W-1:0] slot_q [NUM_PAGES];
    logic [PAGE_W-1:0] rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              empty;
    logic              do_push, do_pop;

    function automatic logic [PAGE_W-1:0] bump(input logic [PAGE_W-1:0] p);
        return (p == PAGE_W'(NUM_PAGES - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count_q == '0);
    // an empty pool forwards a page freed in the same cycle
    assign avail   = !empty || push;
    assign head_id = empty ? push_id : slot_q[rd_ptr_q];
    assign do_push = push && !(empty && pop);
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PAGES; i++) begin
                slot_q[i] <= PAGE_W'(i);
            end
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= CNT_W'(NUM_PAGES);
        end else begin
            if (do_push) begin
                slot_q[wr_ptr_q] <= push_id;
                wr_ptr_q         <= bump(wr_ptr_q);
            end
            if (do_pop) begin
                rd_ptr_q <= bump(rd_ptr_q);
            end
            if (do_push && !do_pop) begin
                count_q <= count_q + 1'b1;
            end else if (do_pop && !do_push) begin
                count_q <= count_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/plm_link_table.sv
module plm_link_table #(
    parameter int NUM_PAGES  = plm_pkg::DEF_NUM_PAGES,
    parameter int PAGE_BYTES = plm_pkg::DEF_PAGE_BYTES
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  we,
    input  logic [plm_pkg::idx_w(NUM_PAGES)-1:0]  wpage,
    input  logic [plm_pkg::idx_w(NUM_PAGES)-1:0]  wnext,
    input  logic [plm_pkg::cnt_w(PAGE_BYTES)-1:0] wfill,
    input  logic [plm_pkg::idx_w(NUM_PAGES)-1:0]  rpage,
    output logic [plm_pkg::idx_w(NUM_PAGES)-1:0]  rnext,
    output logic [plm_pkg::cnt_w(PAGE_BYTES)-1:0] rfill
);
    localparam int PAGE_W = plm_pkg::idx_w(NUM_PAGES);
    localparam int LEN_W  = plm_pkg::cnt_w(PAGE_BYTES);

    logic [PAGE_W-1:0] next_q [NUM_PAGES];
    logic [LEN_W-1:0]  fill_q [NUM_PAGES];

    assign rnext = next_q[rpage];
    assign rfill = fill_q[rpage];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PAGES; i++) begin
                next_q[i] <= '0;
                fill_q[i] <= '0;
            end
        end else if (we) begin
            next_q[wpage] <= wnext;
            fill_q[wpage] <= wfill;
        end
    end

endmodule

// File: rtl/page_list_map.sv
module page_list_map #(
    parameter int NUM_DEST   = plm_pkg::DEF_NUM_DEST,
    parameter int NUM_PAGES  = plm_pkg::DEF_NUM_PAGES,
    parameter int PAGE_BYTES = plm_pkg::DEF_PAGE_BYTES
) (
    input  logic                                              clk,
    input  logic                                              rst,
    input  logic                                              wr_req,
    input  logic [plm_pkg::idx_w(NUM_DEST)-1:0]               wr_dest,
    input  logic [plm_pkg::cnt_w(PAGE_BYTES)-1:0]             wr_len,
    input  logic                                              rd_req,
    input  logic [plm_pkg::idx_w(NUM_DEST)-1:0]               rd_dest,
    input  logic [plm_pkg::cnt_w(PAGE_BYTES)-1:0]             rd_max,
    output logic                                              wr_ack,
    output logic                                              wr_ok,
    output logic                                              wr_new_page,
    output logic [plm_pkg::idx_w(NUM_PAGES*PAGE_BYTES)-1:0]   wr_addr,
    output logic                                              rd_ack,
    output logic                                              rd_empty,
    output logic                                              rd_release,
    output logic [plm_pkg::idx_w(NUM_PAGES*PAGE_BYTES)-1:0]   rd_addr,
    output logic [plm_pkg::cnt_w(PAGE_BYTES)-1:0]             rd_len,
    output logic [plm_pkg::cnt_w(PAGE_BYTES)-1:0]             rd_pad,
    output logic [plm_pkg::cnt_w(NUM_PAGES*PAGE_BYTES)-1:0]   rd_left
);
    import plm_pkg::*;

    localparam int PAGE_W = idx_w(NUM_PAGES);
    localparam int LEN_W  = cnt_w(PAGE_BYTES);
    localparam int ADDR_W = idx_w(NUM_PAGES * PAGE_BYTES);
    localparam int CNT_W  = cnt_w(NUM_PAGES * PAGE_BYTES);

    typedef struct packed {
        logic              valid;
        logic [PAGE_W-1:0] head;
        logic [PAGE_W-1:0] tail;
        logic [LEN_W-1:0]  rd_off;
        logic [LEN_W-1:0]  wr_off;
        logic [CNT_W-1:0]  bytes;
    } list_entry_t;

    function automatic logic [ADDR_W-1:0] mk_addr(input logic [PAGE_W-1:0] pg,
                                                  input logic [LEN_W-1:0]  off);
        return ADDR_W'(pg) * ADDR_W'(PAGE_BYTES) + ADDR_W'(off);
    endfunction

    function automatic logic room_for(input logic [LEN_W-1:0] off,
                                      input logic [LEN_W-1:0] len);
        return ({1'b0, off} + {1'b0, len}) <= (LEN_W + 1)'(PAGE_BYTES);
    endfunction

    list_entry_t entry_q [NUM_DEST];

    // free pool and link table hookup
    logic              pool_push, pool_pop, pool_avail;
    logic [PAGE_W-1:0] pool_push_id, pool_head;
    logic              lt_we;
    logic [PAGE_W-1:0] lt_wpage, lt_wnext, lt_rnext;
    logic [LEN_W-1:0]  lt_wfill, lt_rfill;

    // read phase
    list_entry_t       e_r, r_next;
    logic              r_live, r_sole, same_dest, len_ok, fit_old;
    logic [LEN_W-1:0]  r_top, r_avail, r_len;
    rd_action_e        r_act;

    // write phase
    list_entry_t       w_base, w_next;
    logic              w_fit, w_ok, w_alloc;
    logic [ADDR_W-1:0] w_addr;

    plm_free_pool #(
        .NUM_PAGES (NUM_PAGES)
    ) pool_i (
        .clk     (clk),
        .rst     (rst),
        .push    (pool_push),
        .push_id (pool_push_id),
        .pop     (pool_pop),
        .avail   (pool_avail),
        .head_id (pool_head)
    );

    plm_link_table #(
        .NUM_PAGES  (NUM_PAGES),
        .PAGE_BYTES (PAGE_BYTES)
    ) links_i (
        .clk   (clk),
        .rst   (rst),
        .we    (lt_we),
        .wpage (lt_wpage),
        .wnext (lt_wnext),
        .wfill (lt_wfill),
        .rpage (e_r.head),
        .rnext (lt_rnext),
        .rfill (lt_rfill)
    );

    // read phase: acts on the stored entry
    always_comb begin
        e_r       = entry_q[rd_dest];
        same_dest = rd_req && wr_req && (rd_dest == wr_dest);
        len_ok    = (wr_len != '0) && (wr_len <= LEN_W'(PAGE_BYTES));
        r_live    = rd_req && e_r.valid;
        r_sole    = (e_r.head == e_r.tail);
        r_top     = r_sole ? e_r.wr_off : lt_rfill;
        r_avail   = r_top - e_r.rd_off;
        r_len     = (rd_max < r_avail) ? rd_max : r_avail;
        fit_old   = room_for(e_r.wr_off, wr_len);

        if (!r_live) begin
            r_act = RD_NONE;
        end else if (r_len != r_avail) begin
            r_act = RD_PARTIAL;
        end else if (r_sole && same_dest && len_ok && fit_old) begin
            r_act = RD_KEEP;
        end else begin
            r_act = RD_RELEASE;
        end

        r_next = e_r;
        unique case (r_act)
            RD_PARTIAL: begin
                r_next.rd_off = e_r.rd_off + r_len;
                r_next.bytes  = e_r.bytes - CNT_W'(r_len);
            end
            RD_KEEP: begin
                r_next.rd_off = e_r.wr_off;
                r_next.bytes  = e_r.bytes - CNT_W'(r_len);
            end
            RD_RELEASE: begin
                r_next.bytes  = e_r.bytes - CNT_W'(r_len);
                r_next.rd_off = '0;
                if (r_sole) begin
                    r_next.valid  = 1'b0;
                    r_next.wr_off = '0;
                end else begin
                    r_next.head = lt_rnext;
                end
            end
            default: ;
        endcase

        pool_push    = (r_act == RD_RELEASE);
        pool_push_id = e_r.head;
    end

    // write phase: acts on the result of a read to the same list
    always_comb begin
        w_base  = same_dest ? r_next : entry_q[wr_dest];
        w_fit   = w_base.valid && room_for(w_base.wr_off, wr_len);
        w_ok    = wr_req && len_ok && (w_fit || pool_avail);
        w_alloc = w_ok && !w_fit;
        w_addr  = w_fit ? mk_addr(w_base.tail, w_base.wr_off) : mk_addr(pool_head, '0);

        w_next = w_base;
        if (w_ok) begin
            w_next.bytes = w_base.bytes + CNT_W'(wr_len);
            if (w_fit) begin
                w_next.wr_off = w_base.wr_off + wr_len;
            end else begin
                w_next.valid  = 1'b1;
                w_next.tail   = pool_head;
                w_next.wr_off = wr_len;
                if (!w_base.valid) begin
                    w_next.head   = pool_head;
                    w_next.rd_off = '0;
                end
            end
        end

        pool_pop = w_alloc;
        lt_we    = w_alloc && w_base.valid;
        lt_wpage = w_base.tail;
        lt_wnext = pool_head;
        lt_wfill = w_base.wr_off;
    end

    // list entries
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < NUM_DEST; d++) begin
                entry_q[d] <= '0;
            end
        end else begin
            for (int d = 0; d < NUM_DEST; d++) begin
                if (wr_req && (wr_dest == ($bits(wr_dest))'(d))) begin
                    entry_q[d] <= w_next;
                end else if (rd_req && (rd_dest == ($bits(rd_dest))'(d))) begin
                    entry_q[d] <= r_next;
                end
            end
        end
    end

    // registered replies
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ack      <= 1'b0;
            wr_ok       <= 1'b0;
            wr_new_page <= 1'b0;
            wr_addr     <= '0;
            rd_ack      <= 1'b0;
            rd_empty    <= 1'b0;
            rd_release  <= 1'b0;
            rd_addr     <= '0;
            rd_len      <= '0;
            rd_pad      <= '0;
            rd_left     <= '0;
        end else begin
            wr_ack      <= wr_req;
            wr_ok       <= w_ok;
            wr_new_page <= w_alloc;
            wr_addr     <= w_ok ? w_addr : '0;
            rd_ack      <= rd_req;
            rd_empty    <= !r_live || (r_len == '0);
            rd_release  <= (r_act == RD_RELEASE);
            rd_addr     <= r_live ? mk_addr(e_r.head, e_r.rd_off) : '0;
            rd_len      <= r_live ? r_len : '0;
            rd_pad      <= (r_act == RD_RELEASE) ? (LEN_W'(PAGE_BYTES) - r_top) : '0;
            rd_left     <= r_live ? r_next.bytes : '0;
        end
    end

endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
    parameter int NUM_DEST   = plm_pkg::DEF_NUM_DEST,
    parameter int NUM_PAGES  = plm_pkg::DEF_NUM_PAGES,
    parameter int PAGE_BYTES = plm_pkg::DEF_PAGE_BYTES
) (
    input logic                                            clk,
    input logic                                            rst,
    input logic                                            wr_req,
    input logic [plm_pkg::cnt_w(PAGE_BYTES)-1:0]           wr_len,
    input logic                                            rd_req,
    input logic [plm_pkg::cnt_w(PAGE_BYTES)-1:0]           rd_max,
    input logic                                            wr_ack,
    input logic                                            wr_ok,
    input logic                                            wr_new_page,
    input logic [plm_pkg::idx_w(NUM_PAGES*PAGE_BYTES)-1:0] wr_addr,
    input logic                                            rd_ack,
    input logic                                            rd_empty,
    input logic                                            rd_release,
    input logic [plm_pkg::idx_w(NUM_PAGES*PAGE_BYTES)-1:0] rd_addr,
    input logic [plm_pkg::cnt_w(PAGE_BYTES)-1:0]           rd_len,
    input logic [plm_pkg::cnt_w(PAGE_BYTES)-1:0]           rd_pad
);

    assert_wr_reply_R11: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> wr_ack);

    assert_wr_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> !wr_ack);

    assert_rd_reply_R11: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_ack);

    assert_bad_len_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_req && ((int'(wr_len) == 0) || (int'(wr_len) > PAGE_BYTES))) |=> !wr_ok);

    assert_in_page_R3: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> (!wr_ok ||
                    ((int'(wr_addr) % PAGE_BYTES) + int'($past(wr_len)) <= PAGE_BYTES)));

    assert_new_page_base_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && wr_new_page) |-> (wr_ok && ((int'(wr_addr) % PAGE_BYTES) == 0)));

    assert_len_cap_R6: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> (rd_len <= $past(rd_max)));

    assert_empty_len_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && rd_empty) |-> (rd_len == '0));

    assert_release_span_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && rd_release && !rd_empty) |->
        ((int'(rd_addr) % PAGE_BYTES) + int'(rd_len) + int'(rd_pad) == PAGE_BYTES));

endmodule

bind page_list_map plm_checker #(
    .NUM_DEST   (NUM_DEST),
    .NUM_PAGES  (NUM_PAGES),
    .PAGE_BYTES (PAGE_BYTES)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_req      (wr_req),
    .wr_len      (wr_len),
    .rd_req      (rd_req),
    .rd_max      (rd_max),
    .wr_ack      (wr_ack),
    .wr_ok       (wr_ok),
    .wr_new_page (wr_new_page),
    .wr_addr     (wr_addr),
    .rd_ack      (rd_ack),
    .rd_empty    (rd_empty),
    .rd_release  (rd_release),
    .rd_addr     (rd_addr),
    .rd_len      (rd_len),
    .rd_pad      (rd_pad)
);

// File: tb/page_list_map_tb_top.sv
module page_list_map_tb_top;

    localparam int NDEST  = 4;
    localparam int NPAGES = 8;
    localparam int PB     = 16;
    localparam int DW     = plm_pkg::idx_w(NDEST);
    localparam int LW     = plm_pkg::cnt_w(PB);
    localparam int AW     = plm_pkg::idx_w(NPAGES * PB);
    localparam int CW     = plm_pkg::cnt_w(NPAGES * PB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_req = 1'b0, rd_req = 1'b0;
    logic [DW-1:0] wr_dest = '0, rd_dest = '0;
    logic [LW-1:0] wr_len = '0, rd_max = '0;
    logic          wr_ack, wr_ok, wr_new_page;
    logic [AW-1:0] wr_addr, rd_addr;
    logic          rd_ack, rd_empty, rd_release;
    logic [LW-1:0] rd_len, rd_pad;
    logic [CW-1:0] rd_left;

    always #4 clk = ~clk;

    page_list_map #(
        .NUM_DEST   (NDEST),
        .NUM_PAGES  (NPAGES),
        .PAGE_BYTES (PB)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_req      (wr_req),
        .wr_dest     (wr_dest),
        .wr_len      (wr_len),
        .rd_req      (rd_req),
        .rd_dest     (rd_dest),
        .rd_max      (rd_max),
        .wr_ack      (wr_ack),
        .wr_ok       (wr_ok),
        .wr_new_page (wr_new_page),
        .wr_addr     (wr_addr),
        .rd_ack      (rd_ack),
        .rd_empty    (rd_empty),
        .rd_release  (rd_release),
        .rd_addr     (rd_addr),
        .rd_len      (rd_len),
        .rd_pad      (rd_pad),
        .rd_left     (rd_left)
    );

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    // arithmetic model: per destination a queue of pages with their fill
    int  pg_q [NDEST][$];
    int  fl_q [NDEST][$];
    int  roff [NDEST];
    int  pool [$];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int left_of(input int d);
        int s = 0;
        foreach (fl_q[d][i]) s += fl_q[d][i];
        return s - roff[d];
    endfunction

    task automatic step(input bit wv, input int wd, input int wl,
                        input bit rv, input int rd, input int rm, input string tag);
        bit e_rempty, e_rrel, e_wok, e_wnew;
        int e_raddr, e_rlen, e_rpad, e_rleft, e_waddr;
        e_rempty = 1; e_rrel = 0; e_rlen = 0; e_rpad = 0; e_rleft = 0; e_raddr = 0;
        e_wok = 0; e_wnew = 0; e_waddr = 0;
        // read first
        if (rv && pg_q[rd].size() > 0) begin
            int  avail, rlen;
            bit  sole, keep;
            sole    = (pg_q[rd].size() == 1);
            avail   = fl_q[rd][0] - roff[rd];
            rlen    = (rm < avail) ? rm : avail;
            e_raddr = pg_q[rd][0] * PB + roff[rd];
            e_rlen  = rlen;
            e_rempty = (rlen == 0);
            keep = sole && (rlen == avail) && wv && (wd == rd) && wl >= 1 && wl <= PB
                   && (fl_q[rd][0] + wl <= PB);
            if (rlen == avail && !keep) begin
                e_rrel = 1;
                e_rpad = PB - fl_q[rd][0];
                pool.push_back(pg_q[rd][0]);
                void'(pg_q[rd].pop_front());
                void'(fl_q[rd].pop_front());
                roff[rd] = 0;
            end else if (keep) begin
                roff[rd] = fl_q[rd][0];
            end else begin
                roff[rd] += rlen;
            end
            e_rleft = left_of(rd);
        end
        // then write
        if (wv && wl >= 1 && wl <= PB) begin
            int  last;
            bit  fits;
            last = pg_q[wd].size() - 1;
            fits = (last >= 0) && (fl_q[wd][last] + wl <= PB);
            if (fits) begin
                e_wok   = 1;
                e_waddr = pg_q[wd][last] * PB + fl_q[wd][last];
                fl_q[wd][last] += wl;
            end else if (pool.size() > 0) begin
                int n;
                n = pool.pop_front();
                e_wok = 1; e_wnew = 1;
                e_waddr = n * PB;
                if (last < 0) roff[wd] = 0;
                pg_q[wd].push_back(n);
                fl_q[wd].push_back(wl);
            end
        end
        wr_req  = wv; wr_dest = DW'(wd); wr_len = LW'(wl);
        rd_req  = rv; rd_dest = DW'(rd); rd_max = LW'(rm);
        @(negedge clk);
        chk(tag, "wr_ack", int'(wr_ack), int'(wv));
        chk(tag, "rd_ack", int'(rd_ack), int'(rv));
        if (wv) begin
            chk(tag, "wr_ok", int'(wr_ok), int'(e_wok));
            if (e_wok) begin
                chk(tag, "wr_addr", int'(wr_addr), e_waddr);
                chk(tag, "wr_new_page", int'(wr_new_page), int'(e_wnew));
            end
        end
        if (rv) begin
            chk(tag, "rd_empty", int'(rd_empty), int'(e_rempty));
            chk(tag, "rd_len", int'(rd_len), e_rlen);
            chk(tag, "rd_release", int'(rd_release), int'(e_rrel));
            chk(tag, "rd_pad", int'(rd_pad), e_rpad);
            chk(tag, "rd_left", int'(rd_left), e_rleft);
            if (!e_rempty) chk(tag, "rd_addr", int'(rd_addr), e_raddr);
        end
        wr_req = 1'b0; rd_req = 1'b0;
    endtask

    task automatic wr(input int d, input int l, input string tag);
        step(1, d, l, 0, 0, 0, tag);
    endtask

    task automatic rdq(input int d, input int m, input string tag);
        step(0, 0, 0, 1, d, m, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int lfsr;
        for (int i = 0; i < NPAGES; i++) pool.push_back(i);
        for (int d = 0; d < NDEST; d++) roff[d] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "wr_ack", int'(wr_ack), 0);
        chk("R1", "rd_ack", int'(rd_ack), 0);
        // R7: every list empty after reset
        for (int d = 0; d < NDEST; d++) rdq(d, PB, "R7");
        // R5: illegal lengths leave the list empty
        wr(0, 0, "R5");
        wr(0, PB + 1, "R5");
        rdq(0, PB, "R5");
        // R2 and R1: first page comes from pool head (page 0)
        wr(0, 5, "R2");
        // R3: appends inside the tail page
        wr(0, 5, "R3");
        wr(0, 6, "R3");
        // R4: overflow links page 1
        wr(0, 3, "R4");
        wr(1, PB, "R2");
        // R6: partial read, then R8 releases a full page, then a padded page
        rdq(0, 4, "R6");
        rdq(0, 0, "R7");
        rdq(0, PB, "R8");
        rdq(0, PB, "R9");
        rdq(0, PB, "R7");
        // R12: exhaust the pool and check the reuse order
        for (int k = 0; k < NPAGES; k++) wr(2 + (k % 2), PB, "R12");
        wr(0, 1, "R5");
        // R12: release while pool empty, same-cycle write of another list takes it
        step(1, 0, 4, 1, 1, PB, "R12");
        // drain everything
        for (int d = 0; d < NDEST; d++)
            for (int k = 0; k < NPAGES + 1; k++) rdq(d, PB, "R8");
        // R10: collision where the write fits after the drained data
        wr(3, 8, "R10");
        step(1, 3, 4, 1, 3, 8, "R10");
        rdq(3, PB, "R10");
        // R10: collision where the write does not fit
        wr(3, 8, "R10");
        step(1, 3, 12, 1, 3, 8, "R10");
        rdq(3, PB, "R10");
        // R10: collision with a partial read on a multi-page list
        wr(2, 10, "R10");
        wr(2, 10, "R10");
        step(1, 2, 6, 1, 2, 3, "R10");
        step(1, 2, 9, 1, 2, PB, "R10");
        // R11: concurrent traffic on different lists
        step(1, 1, 7, 1, 2, PB, "R11");
        step(1, 0, 16, 1, 1, 2, "R11");
        // sweep: pseudo-random request pairs against the model
        lfsr = 32'h1ace_b00c;
        for (int it = 0; it < 4000; it++) begin
            bit wv, rv;
            int wd, wl, rd, rm;
            lfsr = (lfsr << 1) ^ ((lfsr < 0) ? 32'h04c1_1db7 : 0);
            wv = lfsr[3];
            rv = lfsr[9] | lfsr[10];
            wd = (lfsr >>> 4) & 3;
            rd = (lfsr >>> 11) & 3;
            wl = ((lfsr >>> 14) & 31) % (PB + 2);
            rm = ((lfsr >>> 20) & 31) % (PB + 1);
            if (it % 5 == 0) rd = wd;
            step(wv, wd, wl, rv, rd, rm, (wv && rv && wd == rd) ? "R10" : "R11");
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule